// File: doc/BRIEF.md
# Exact-Ratio Phase Accumulator Synthesizer

This block is the phase engine of a direct digital synthesizer whose modulus is not a power of two. With the default parameters it runs from a 10 MHz clock and produces a phase that completes exactly 60 revolutions per second. The ratio 60 / 10,000,000 reduces to 3 / 500000, so the phase advances by 3 on every clock, modulo 500000. A binary modulus cannot hold this ratio exactly and would drift slowly over time; this block has no drift at all.

Two internal engines run side by side on every clock. The first is an add-and-fold accumulator. The second is a down counter that reloads its top value when it passes zero; its count is mapped to a phase by multiplying and folding. Both engines produce the same phase sequence. A mode pin picks which engine drives the outputs. The engines differ only in the wrap strobe. In counter mode one counter cycle spans several phase revolutions, each starting from a different alignment, so that mode strobes once per counter cycle. The phase output is wide enough to address a waveform table placed after the block. A square wave is taken at the half-way point of the phase.

Top module: `exdds_synth`

## Requirements
- R1: While rst_n is low (asynchronous, active low), phase is 0, wrap is 0 and square is 1 in both modes. The internal down counter holds MODULUS-1.
- R2: phase is always in the range 0 to MODULUS-1.
- R3: With count_mode = 0, each rising clock edge sets phase to the old phase plus STEP. When that sum is MODULUS or more, MODULUS is subtracted in the same cycle. After n clock edges since reset, phase = (STEP·n) mod MODULUS.
- R4: The defaults are MODULUS = 500000 and STEP = 3, which gives a 19-bit phase. From reset, the first wrap in accumulator mode appears after exactly 166667 clock edges, with phase = 1.
- R5: With count_mode = 1, phase = (STEP·(MODULUS-1-count)) mod MODULUS. The count decrements by one per clock and reloads MODULUS-1 after 0, so phase matches the R3 sequence.
- R6: Both engines advance on every clock whatever the mode. Changing count_mode on any cycle leaves phase on the single sequence (STEP·n) mod MODULUS.
- R7: square is 1 exactly when phase < MODULUS/2 (integer division), and 0 otherwise.
- R8: With count_mode = 0, wrap is 1 for exactly the cycles in which the current phase value came from a subtraction of MODULUS.
- R9: With count_mode = 1, wrap is 1 for exactly the cycles after the down counter reloaded from 0. That is once every MODULUS clocks, at n = k·MODULUS with k ≥ 1, when phase is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Reference clock; one phase step per rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| count_mode | input | 1 | 0 selects the accumulator engine, 1 selects the down-counter engine |
| phase | output | $clog2(MODULUS) | Current phase, 0 to MODULUS-1 |
| square | output | 1 | High in the first half of each phase revolution |
| wrap | output | 1 | One-cycle strobe: phase fold (mode 0) or counter reload (mode 1) |

## Verification
The properties assume that STEP is smaller than MODULUS, that count_mode and rst_n are always at known levels, and that reset is released away from a rising clock edge. Phase continuity is checked across every edge no matter how count_mode moves, because both engines always advance. The stimulus holds to these assumptions. It changes count_mode and rst_n only at falling edges, and count_mode changes both in long runs and at random on single cycles. A reduced-modulus instance covers counter reloads in a short run, and a default-parameter instance covers the exact first fold at 166667 clocks.

// File: rtl/exdds_pkg.sv
package exdds_pkg;

  // Engine that drives the block outputs
  typedef enum logic {
    ENG_ACCUM = 1'b0,
    ENG_COUNT = 1'b1
  } engine_e;

  // Default ratio: 60 Hz from a 10 MHz clock, reduced to 3/500000
  localparam int DEF_MODULUS = 500000;
  localparam int DEF_STEP    = 3;

endpackage

// File: rtl/exdds_accum.sv
module exdds_accum #(
  parameter int MODULUS = 500000,
  parameter int STEP    = 3,
  localparam int PW     = $clog2(MODULUS),
  localparam int SW     = PW + 1
) (
  input  logic          clk,
  input  logic          rst_n,
  output logic [PW-1:0] acc_phase,
  output logic          acc_fold
);

  logic [SW-1:0] sum;
  logic [SW-1:0] folded;
  logic          over;

  always_comb begin
    sum    = SW'(acc_phase) + SW'(STEP);
    over   = (sum >= SW'(MODULUS));
    folded = over ? (sum - SW'(MODULUS)) : sum;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      acc_phase <= '0;
      acc_fold  <= 1'b0;
    end else begin
      acc_phase <= folded[PW-1:0];
      acc_fold  <= over;
    end
  end

endmodule

// File: rtl/exdds_down.sv
module exdds_down #(
  parameter int MODULUS = 500000,
  localparam int PW     = $clog2(MODULUS)
) (
  input  logic          clk,
  input  logic          rst_n,
  output logic [PW-1:0] count,
  output logic          reloaded
);

  localparam logic [PW-1:0] TOP = PW'(MODULUS - 1);

  logic at_zero;

  always_comb at_zero = (count == '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      count    <= TOP;
      reloaded <= 1'b0;
    end else begin
      count    <= at_zero ? TOP : (count - PW'(1));
      reloaded <= at_zero;
    end
  end

endmodule

// File: rtl/exdds_map.sv
module exdds_map #(
  parameter int MODULUS = 500000,
  parameter int STEP    = 3,
  localparam int PW     = $clog2(MODULUS),
  localparam int PRW    = PW + $clog2(STEP + 1) + 1
) (
  input  logic [PW-1:0] count,
  output logic [PW-1:0] map_phase
);

  logic [PW-1:0] elapsed;

  // Steps taken since the last reload
  always_comb elapsed = PW'(MODULUS - 1) - count;

  generate
    if (STEP == 1) begin : g_unit
      always_comb map_phase = elapsed;
    end else begin : g_scaled
      logic [PRW-1:0] prod;
      always_comb begin
        prod = PRW'(elapsed) * PRW'(STEP);
        // prod < STEP*MODULUS, so STEP folds are enough
        for (int i = 0; i < STEP; i++) begin
          if (prod >= PRW'(MODULUS)) prod = prod - PRW'(MODULUS);
        end
        map_phase = prod[PW-1:0];
      end
    end
  endgenerate

endmodule

// File: rtl/exdds_shape.sv
module exdds_shape
  import exdds_pkg::*;
#(
  parameter int MODULUS = 500000,
  localparam int PW     = $clog2(MODULUS)
) (
  input  engine_e       engine,
  input  logic [PW-1:0] acc_phase,
  input  logic          acc_fold,
  input  logic [PW-1:0] cnt_phase,
  input  logic          cnt_reload,
  output logic [PW-1:0] phase,
  output logic          square,
  output logic          wrap
);

  localparam logic [PW-1:0] HALF = PW'(MODULUS / 2);

  always_comb begin
    if (engine == ENG_COUNT) begin
      phase = cnt_phase;
      wrap  = cnt_reload;
    end else begin
      phase = acc_phase;
      wrap  = acc_fold;
    end
    square = (phase < HALF);
  end

endmodule

// File: rtl/exdds_synth.sv
module exdds_synth
  import exdds_pkg::*;
#(
  parameter int MODULUS = DEF_MODULUS,
  parameter int STEP    = DEF_STEP,
  localparam int PW     = $clog2(MODULUS)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          count_mode,
  output logic [PW-1:0] phase,
  output logic          square,
  output logic          wrap
);

  logic [PW-1:0] acc_phase;
  logic          acc_fold;
  logic [PW-1:0] count;
  logic          reloaded;
  logic [PW-1:0] cnt_phase;
  engine_e       engine;

  always_comb engine = engine_e'(count_mode);

  exdds_accum #(.MODULUS(MODULUS), .STEP(STEP)) u_accum (
    .clk       (clk),
    .rst_n     (rst_n),
    .acc_phase (acc_phase),
    .acc_fold  (acc_fold)
  );

  exdds_down #(.MODULUS(MODULUS)) u_down (
    .clk      (clk),
    .rst_n    (rst_n),
    .count    (count),
    .reloaded (reloaded)
  );

  exdds_map #(.MODULUS(MODULUS), .STEP(STEP)) u_map (
    .count     (count),
    .map_phase (cnt_phase)
  );

  exdds_shape #(.MODULUS(MODULUS)) u_shape (
    .engine     (engine),
    .acc_phase  (acc_phase),
    .acc_fold   (acc_fold),
    .cnt_phase  (cnt_phase),
    .cnt_reload (reloaded),
    .phase      (phase),
    .square     (square),
    .wrap       (wrap)
  );

endmodule

// File: rtl/exdds_synth_chk.sv
module exdds_synth_chk #(
  parameter int MODULUS = 500000,
  parameter int STEP    = 3,
  localparam int PW     = $clog2(MODULUS)
) (
  input logic          clk,
  input logic          rst_n,
  input logic          count_mode,
  input logic [PW-1:0] phase,
  input logic          square,
  input logic          wrap
);

  localparam int HALF = MODULUS / 2;

  // R1: reset state seen at the ports
  a_r1_reset_state: assert property (@(posedge clk)
    !rst_n |-> (phase == '0 && !wrap && square));

  // R2: phase range
  a_r2_in_range: assert property (@(posedge clk) disable iff (!rst_n)
    phase < PW'(MODULUS));

  // R3, R5, R6: one step per clock, whatever the mode
  a_r6_continuous_step: assert property (@(posedge clk) disable iff (!rst_n)
    $past(rst_n) |-> phase == PW'((longint'($past(phase)) + STEP) % MODULUS));

  // R7: square rises only just after a fold, falls only just past half
  a_r7_square_rise: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(square) |-> phase < PW'(STEP));
  a_r7_square_fall: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(square) |-> (phase >= PW'(HALF) && phase < PW'(HALF + STEP)));

  // R8: accumulator fold strobe
  a_r8_fold_marks_small: assert property (@(posedge clk) disable iff (!rst_n)
    (!count_mode && wrap) |-> phase < PW'(STEP));
  a_r8_fold_seen: assert property (@(posedge clk) disable iff (!rst_n)
    (!count_mode && $past(rst_n) && phase < $past(phase)) |-> wrap);

  // R9: counter reload strobe lands on phase zero
  a_r9_reload_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (count_mode && wrap) |-> phase == '0);

endmodule

bind exdds_synth exdds_synth_chk #(.MODULUS(MODULUS), .STEP(STEP)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .count_mode (count_mode),
  .phase      (phase),
  .square     (square),
  .wrap       (wrap)
);

// File: tb/exdds_synth_bench.sv
`timescale 1ns/1ps
module exdds_synth_bench;

  localparam int CLK_PERIOD = 100;
  localparam int SM   = 500;
  localparam int SSTP = 3;
  localparam int FM   = 500000;
  localparam int FSTP = 3;
  localparam int SPW  = $clog2(SM);
  localparam int FPW  = $clog2(FM);

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic count_mode = 1'b0;
  logic [SPW-1:0] s_phase;
  logic s_square, s_wrap;
  logic [FPW-1:0] f_phase;
  logic f_square, f_wrap;

  int checks = 0;
  int errors = 0;
  longint n = 0;
  int cyc = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  exdds_synth #(.MODULUS(SM), .STEP(SSTP)) u_exdds_synth (
    .clk(clk), .rst_n(rst_n), .count_mode(count_mode),
    .phase(s_phase), .square(s_square), .wrap(s_wrap));

  exdds_synth u_exdds_synth_full (
    .clk(clk), .rst_n(rst_n), .count_mode(count_mode),
    .phase(f_phase), .square(f_square), .wrap(f_wrap));

  function automatic longint exp_phase(longint k, longint m, longint s);
    return (s * k) % m;
  endfunction

  function automatic logic exp_wrap(longint k, longint m, longint s, logic cm);
    if (k == 0) return 1'b0;
    if (cm) return (k % m) == 0;
    return ((s * k) / m) != ((s * (k - 1)) / m);
  endfunction

  task automatic chk(input string tag, input longint act, input longint exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual %0d expected %0d (n=%0d mode=%0d)", tag, act, exp, n, count_mode);
    end
  endtask

  task automatic check_small(input string ptag, input string wtag);
    longint ep;
    ep = exp_phase(n, SM, SSTP);
    chk(ptag, s_phase, ep);
    chk("R2", longint'(s_phase < SPW'(SM)), 1);
    chk("R7", s_square, longint'(ep < SM / 2));
    chk(wtag, s_wrap, exp_wrap(n, SM, SSTP, count_mode));
  endtask

  task automatic check_full(input string ptag, input string wtag);
    longint ep;
    ep = exp_phase(n, FM, FSTP);
    chk(ptag, f_phase, ep);
    chk("R7", f_square, longint'(ep < FM / 2));
    chk(wtag, f_wrap, exp_wrap(n, FM, FSTP, count_mode));
  endtask

  task automatic tick();
    @(posedge clk);
    if (rst_n) n++;
    @(negedge clk);
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0;
    n = 0;
    #1;
    for (int m = 0; m < 2; m++) begin
      count_mode = m[0];
      #1;
      chk("R1", s_phase, 0);
      chk("R1", s_wrap, 0);
      chk("R1", s_square, 1);
      chk("R1", f_phase, 0);
      chk("R1", f_wrap, 0);
    end
    @(negedge clk);
    rst_n = 1'b1;
    #1;
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 195000) begin
      checks++;
      errors++;
      $display("FAIL watchdog expired at cycle %0d", cyc);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h5eed_0060));
    do_reset();

    // accumulator engine, several folds (R3, R8)
    count_mode = 1'b0;
    for (int i = 0; i < 600; i++) begin
      tick();
      #1;
      check_small("R3", "R8");
      check_full("R3", "R8");
    end

    // counter engine, covers reloads at n = 1000 and 1500 (R5, R9)
    count_mode = 1'b1;
    for (int i = 0; i < 1100; i++) begin
      tick();
      #1;
      check_small("R5", "R9");
      check_full("R5", "R9");
    end

    // random mode changes on single cycles (R6)
    for (int i = 0; i < 3000; i++) begin
      tick();
      count_mode = ($urandom % 4) == 0 ? ~count_mode : count_mode;
      #1;
      check_small("R6", count_mode ? "R9" : "R8");
      check_full("R6", count_mode ? "R9" : "R8");
    end

    // reset in mid run (R1), then exact first fold at default ratio (R4)
    do_reset();
    count_mode = 1'b0;
    chk("R4", FPW, 19);
    while (n < 166665) tick();
    for (int i = 0; i < 4; i++) begin
      tick();
      #1;
      check_full("R4", "R4");
      if (n == 166667) begin
        chk("R4", f_wrap, 1);
        chk("R4", f_phase, 1);
      end
    end
    count_mode = 1'b1;
    #1;
    check_full("R5", "R9");

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule